// File: doc/BRIEF.md
# Device ROM Header Validator

This block watches a byte stream read from a device ROM, beginning at address 0, and decides whether the header at the front of that stream can be trusted. A 64-bit unique identifier is guarded by its own 8-bit checksum. A variable-length payload is guarded by a 32-bit checksum, and the payload's extent comes from a length field carried inside the same stream. The block runs both checks in-line, one byte per accepted beat, so no copy of the ROM is kept.

The block is used in three steps. A one-cycle `start` arms the checker. The bytes are then offered with `byte_valid`, and gaps between them are allowed. After the final byte is taken, `done` pulses once. In that same cycle the verdict, the four error flags, the revision warning, the identifier and both lengths can be read, and they stay put until the next `start`. An expected total size may optionally be supplied, and the computed size must then agree with it.

Top module: `rom_hdr_check`

## Requirements
- R1: The identifier checksum is CRC-8 with polynomial 0x07 and start value 0xFF. Each byte is XORed into the register and then shifted eight times, MSB first, with no final inversion. It runs over bytes 1..8, and if the result differs from byte 0 the result raises `err_id_crc`.
- R2: `uid` holds bytes 1..8 in little-endian order, so byte 1 lands in bits 7:0.
- R3: `data_len` is bits 9:0 of the little-endian word formed from byte 14 (low) and byte 15 (high). Bits 7:2 of byte 15 are ignored. `total_size` equals `data_len` + 13.
- R4: The payload checksum is reflected CRC-32C with polynomial 0x82F63B78, start value all ones and a final inversion. It runs over the `data_len` bytes that begin at byte 13. It is compared with bytes 9..12 read little-endian, and a difference raises `err_data_crc`.
- R5: If `total_size` is below 22, `err_short` is raised and `done` pulses one cycle after byte 15 is accepted. In that case the payload checksum is not judged, so `err_data_crc` stays 0.
- R6: If `exp_size_en` is 1 in the cycle the final byte is accepted and `exp_size` differs from `total_size`, `err_size` is raised.
- R7: If byte 13 is greater than 1, `rev_warn` is raised. This warning has no effect on `pass`.
- R8: The final byte is byte `total_size`-1, or byte 15 for a short ROM. `done` is high for exactly the one cycle that follows the clock edge on which the final byte is accepted.
- R9: In that cycle `pass` is 1 exactly when none of `err_id_crc`, `err_data_crc`, `err_size` and `err_short` is set.
- R10: Bytes offered before any `start`, or after the final byte, change nothing. A `start` abandons any frame in progress, and one cycle later `done`, `pass` and all flags read 0.
- R11: After a synchronous reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arms a new frame at offset 0 |
| byte_valid | input | 1 | `byte_data` carries the next ROM byte |
| byte_data | input | 8 | ROM byte |
| exp_size_en | input | 1 | Enables the expected-size comparison |
| exp_size | input | SIZE_W (11) | Expected total ROM size |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Header accepted |
| err_id_crc | output | 1 | Identifier checksum mismatch |
| err_data_crc | output | 1 | Payload checksum mismatch |
| err_size | output | 1 | Expected size mismatch |
| err_short | output | 1 | Total size below header length |
| rev_warn | output | 1 | Revision byte greater than 1 |
| uid | output | 64 | Unique identifier |
| data_len | output | LEN_BITS (10) | Payload length |
| total_size | output | SIZE_W (11) | Payload length plus 13 |

## Verification
Every verdict has a fixed due cycle: it appears on the ports one clock after the edge that accepts the final byte, which is either byte `total_size`-1 or byte 15 for a short ROM. A flag is due only then. The bench's behavioural model marks the beat that carries the final byte. It registers that mark on the same edge the design uses, and then compares `done` at every falling edge. From the `done` cycle until the next `start`, it compares all result ports on every falling edge, and this covers the trailing bytes that must be ignored. Streams vary the length (0, 5, 9, 12, 40, 200, 1023), the gaps between beats, deliberate checksum corruption, the revision byte, the stray high bits of byte 15, and the expected-size setting.

// File: rtl/rom_hdr_pkg.sv
package rom_hdr_pkg;
  // Fixed header layout; neighbours and software decode these positions.
  localparam int ID_CRC_OFS = 0;
  localparam int UID_OFS    = 1;
  localparam int UID_BYTES  = 8;
  localparam int DCRC_OFS   = 9;
  localparam int DCRC_BYTES = 4;
  localparam int REV_OFS    = 13;
  localparam int LEN_OFS    = 14;

  localparam logic [7:0]  CRC8_POLY   = 8'h07;
  localparam logic [7:0]  CRC8_INIT   = 8'hFF;
  localparam logic [31:0] CRC32C_POLY = 32'h82F63B78;
  localparam logic [31:0] CRC32C_INIT = 32'hFFFF_FFFF;
endpackage

// File: rtl/rhc_crc_acc.sv
module rhc_crc_acc #(
  parameter int           W       = 8,
  parameter logic [W-1:0] POLY    = '0,
  parameter logic [W-1:0] INIT    = '1,
  parameter bit           REFLECT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         en,
  input  logic [7:0]   din,
  output logic [W-1:0] crc_q,
  output logic [W-1:0] crc_nx
);
  generate
    if (REFLECT) begin : g_lsb_first
      always_comb begin
        crc_nx = crc_q ^ W'(din);
        for (int k = 0; k < 8; k++)
          crc_nx = crc_nx[0] ? ((crc_nx >> 1) ^ POLY) : (crc_nx >> 1);
      end
    end else begin : g_msb_first
      always_comb begin
        crc_nx = crc_q ^ (W'(din) << (W - 8));
        for (int k = 0; k < 8; k++)
          crc_nx = crc_nx[W-1] ? ((crc_nx << 1) ^ POLY) : (crc_nx << 1);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= INIT;
    else if (en)      crc_q <= crc_nx;
  end
endmodule

// File: rtl/rhc_field_cap.sv
module rhc_field_cap
  import rom_hdr_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       din,
  output logic [7:0]       id_crc_b,
  output logic [63:0]      uid,
  output logic [31:0]      dcrc,
  output logic [7:0]       rev,
  output logic [7:0]       len_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      id_crc_b <= '0;
      rev      <= '0;
      len_lo   <= '0;
    end else if (take) begin
      if (idx == IDX_W'(ID_CRC_OFS)) id_crc_b <= din;
      if (idx == IDX_W'(REV_OFS))    rev      <= din;
      if (idx == IDX_W'(LEN_OFS))    len_lo   <= din;
    end
  end

  genvar g;
  generate
    for (g = 0; g < UID_BYTES; g++) begin : g_uid
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (take && idx == IDX_W'(UID_OFS + g)) q <= din;
      end
      assign uid[8*g +: 8] = q;
    end
    for (g = 0; g < DCRC_BYTES; g++) begin : g_dcrc
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (take && idx == IDX_W'(DCRC_OFS + g)) q <= din;
      end
      assign dcrc[8*g +: 8] = q;
    end
  endgenerate
endmodule

// File: rtl/rom_hdr_check.sv
module rom_hdr_check
  import rom_hdr_pkg::*;
#(
  parameter  int LEN_BITS   = 10,
  parameter  int DATA_START = 13,
  parameter  int HDR_BYTES  = 22,
  localparam int SIZE_W     = $clog2((1 << LEN_BITS) + DATA_START)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                byte_valid,
  input  logic [7:0]          byte_data,
  input  logic                exp_size_en,
  input  logic [SIZE_W-1:0]   exp_size,
  output logic                done,
  output logic                pass,
  output logic                err_id_crc,
  output logic                err_data_crc,
  output logic                err_size,
  output logic                err_short,
  output logic                rev_warn,
  output logic [63:0]         uid,
  output logic [LEN_BITS-1:0] data_len,
  output logic [SIZE_W-1:0]   total_size
);
  logic              busy;
  logic [SIZE_W-1:0] idx;
  logic              take;
  logic              id_bad;

  logic [7:0]  id_crc_b, rev_b, len_lo;
  logic [31:0] dcrc_stored;
  logic [7:0]  crc8_q, crc8_nx;
  logic [31:0] crc32_q, crc32_nx;

  logic [15:0]         len_word;
  logic [LEN_BITS-1:0] len_now;
  logic [SIZE_W-1:0]   total_now, total_sel;
  logic                at_len_hi, short_now, finish;
  logic                size_bad, data_bad;

  assign take = busy && byte_valid && !start;

  rhc_field_cap #(.IDX_W(SIZE_W)) u_fields (
    .clk(clk), .rst(rst), .take(take), .idx(idx), .din(byte_data),
    .id_crc_b(id_crc_b), .uid(uid), .dcrc(dcrc_stored),
    .rev(rev_b), .len_lo(len_lo)
  );

  rhc_crc_acc #(.W(8), .POLY(CRC8_POLY), .INIT(CRC8_INIT), .REFLECT(1'b0)) u_crc_id (
    .clk(clk), .rst(rst), .clear(start),
    .en(take && idx >= SIZE_W'(UID_OFS) && idx < SIZE_W'(UID_OFS + UID_BYTES)),
    .din(byte_data), .crc_q(crc8_q), .crc_nx(crc8_nx)
  );

  rhc_crc_acc #(.W(32), .POLY(CRC32C_POLY), .INIT(CRC32C_INIT), .REFLECT(1'b1)) u_crc_data (
    .clk(clk), .rst(rst), .clear(start),
    .en(take && idx >= SIZE_W'(DATA_START)),
    .din(byte_data), .crc_q(crc32_q), .crc_nx(crc32_nx)
  );

  // Length arrives in bytes 14/15; use it combinationally on byte 15.
  assign len_word  = {byte_data, len_lo};
  assign len_now   = len_word[LEN_BITS-1:0];
  assign total_now = SIZE_W'(len_now) + SIZE_W'(DATA_START);
  assign at_len_hi = (idx == SIZE_W'(LEN_OFS + 1));
  assign total_sel = at_len_hi ? total_now : total_size;
  assign short_now = at_len_hi && (total_now < SIZE_W'(HDR_BYTES));
  assign finish    = take && (idx >= SIZE_W'(LEN_OFS + 1)) &&
                     (short_now || idx == total_sel - SIZE_W'(1));
  assign size_bad  = exp_size_en && (exp_size != total_sel);
  assign data_bad  = !short_now && ((~crc32_nx) != dcrc_stored);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      idx        <= '0;
      id_bad     <= 1'b0;
      data_len   <= '0;
      total_size <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      idx    <= '0;
      id_bad <= 1'b0;
    end else if (take) begin
      idx <= idx + SIZE_W'(1);
      if (idx == SIZE_W'(UID_OFS + UID_BYTES - 1))
        id_bad <= (crc8_nx != id_crc_b);
      if (at_len_hi) begin
        data_len   <= len_now;
        total_size <= total_now;
      end
      if (finish) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      done         <= 1'b0;
      pass         <= 1'b0;
      err_id_crc   <= 1'b0;
      err_data_crc <= 1'b0;
      err_size     <= 1'b0;
      err_short    <= 1'b0;
      rev_warn     <= 1'b0;
    end else if (finish) begin
      done         <= 1'b1;
      err_id_crc   <= id_bad;
      err_data_crc <= data_bad;
      err_size     <= size_bad;
      err_short    <= short_now;
      rev_warn     <= (rev_b > 8'd1);
      pass         <= !(id_bad || data_bad || size_bad || short_now);
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/rom_hdr_check_chk.sv
module rom_hdr_check_chk #(
  parameter int LEN_BITS   = 10,
  parameter int DATA_START = 13,
  parameter int HDR_BYTES  = 22,
  parameter int SIZE_W     = 11
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                pass,
  input logic                err_id_crc,
  input logic                err_data_crc,
  input logic                err_size,
  input logic                err_short,
  input logic                rev_warn,
  input logic [LEN_BITS-1:0] data_len,
  input logic [SIZE_W-1:0]   total_size
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  // R3
  size_rel_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (total_size == SIZE_W'(data_len) + SIZE_W'(DATA_START)));

  // R5
  short_bound_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (err_short == (total_size < SIZE_W'(HDR_BYTES))));

  // R5
  short_no_data_chk: assert property (@(posedge clk) disable iff (rst)
    err_short |-> !err_data_crc);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(pass) && $stable(err_id_crc) &&
      $stable(err_data_crc) && $stable(err_size) && $stable(err_short) &&
      $stable(rev_warn) && !done));
endmodule

bind rom_hdr_check rom_hdr_check_chk #(
  .LEN_BITS(LEN_BITS), .DATA_START(DATA_START), .HDR_BYTES(HDR_BYTES), .SIZE_W(SIZE_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .pass(pass),
  .err_id_crc(err_id_crc), .err_data_crc(err_data_crc), .err_size(err_size),
  .err_short(err_short), .rev_warn(rev_warn), .data_len(data_len),
  .total_size(total_size)
);

// File: tb/rom_hdr_check_bench.sv
module rom_hdr_check_bench;
  localparam int CLK_P  = 10;
  localparam int SIZE_W = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, byte_valid = 1'b0, exp_size_en = 1'b0;
  logic [7:0] byte_data = '0;
  logic [SIZE_W-1:0] exp_size = '0;
  logic done, pass, err_id_crc, err_data_crc, err_size, err_short, rev_warn;
  logic [63:0] uid;
  logic [9:0] data_len;
  logic [SIZE_W-1:0] total_size;

  always #(CLK_P/2) clk = ~clk;

  rom_hdr_check u_rom_hdr_check (
    .clk(clk), .rst(rst), .start(start), .byte_valid(byte_valid),
    .byte_data(byte_data), .exp_size_en(exp_size_en), .exp_size(exp_size),
    .done(done), .pass(pass), .err_id_crc(err_id_crc), .err_data_crc(err_data_crc),
    .err_size(err_size), .err_short(err_short), .rev_warn(rev_warn),
    .uid(uid), .data_len(data_len), .total_size(total_size)
  );

  int tests = 0, fails = 0;
  logic [7:0] frm [];
  int last_idx;
  logic fire = 1'b0, exp_done = 1'b0, hold = 1'b0;
  logic e_pass, e_id, e_data, e_size, e_short, e_warn;
  logic [63:0] e_uid;
  int e_len, e_total;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_crc8(int from, int to);
    logic [7:0] c = 8'hFF;
    for (int i = from; i <= to; i++) begin
      c ^= frm[i];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [31:0] m_crc32(int from, int to);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = from; i <= to; i++) begin
      c ^= {24'h0, frm[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
    end
    return ~c;
  endfunction

  // Reference model: expectations derived from the frame and the requirements.
  task automatic model();
    e_len   = {frm[15][1:0], frm[14]};
    e_total = e_len + 13;
    e_short = (e_total < 22);
    e_id    = (m_crc8(1, 8) != frm[0]);
    e_data  = !e_short && (m_crc32(13, e_total - 1) != {frm[12], frm[11], frm[10], frm[9]});
    e_size  = exp_size_en && (int'(exp_size) != e_total);
    e_warn  = (frm[13] > 8'd1);
    e_pass  = !(e_id || e_data || e_size || e_short);
    e_uid   = {frm[8], frm[7], frm[6], frm[5], frm[4], frm[3], frm[2], frm[1]};
    last_idx = e_short ? 15 : e_total - 1;
  endtask

  task automatic build(int len, logic [5:0] hi, logic [7:0] rev,
                       bit bad_id, bit bad_data, int seed);
    int total = len + 13;
    int n = (total < 16) ? 16 : total;
    logic [31:0] c32;
    frm = new[n];
    for (int i = 0; i < n; i++) frm[i] = 8'((i * 37 + seed * 11 + 5) ^ (i >> 3));
    frm[13] = rev;
    frm[14] = 8'(len);
    frm[15] = {hi, 2'(len >> 8)};
    frm[0]  = m_crc8(1, 8) ^ {7'h0, bad_id};
    if (total >= 22) begin
      c32 = m_crc32(13, total - 1) ^ {31'h0, bad_data};
      frm[9] = c32[7:0]; frm[10] = c32[15:8]; frm[11] = c32[23:16]; frm[12] = c32[31:24];
    end
    model();
  endtask

  task automatic send(int upto, bit mark, int gap, int trail);
    for (int i = 0; i <= upto; i++) begin
      repeat (gap) begin
        @(negedge clk); byte_valid = 1'b0; fire = 1'b0;
      end
      @(negedge clk); byte_valid = 1'b1; byte_data = frm[i];
      fire = mark && (i == last_idx);
    end
    for (int t = 0; t < trail; t++) begin
      @(negedge clk); byte_valid = 1'b1; byte_data = 8'hA5; fire = 1'b0;
    end
    @(negedge clk); byte_valid = 1'b0; fire = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_start(bit check_clear);
    @(negedge clk); start = 1'b1; byte_valid = 1'b0; fire = 1'b0;
    @(negedge clk); start = 1'b0;
    if (check_clear) begin
      chk("R10 pass cleared by start", pass, 0);
      chk("R10 flags cleared by start",
          {err_id_crc, err_data_crc, err_size, err_short, rev_warn}, 0);
    end
  endtask

  always @(posedge clk) begin
    exp_done <= fire && !rst;
    if (rst || start) hold <= 1'b0;
    else if (fire)    hold <= 1'b1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R8 done timing", done, exp_done);
      if (hold) begin
        chk(exp_done ? "R9 pass" : "R10 pass held", pass, e_pass);
        chk(exp_done ? "R1 err_id_crc" : "R10 err_id held", err_id_crc, e_id);
        chk(exp_done ? "R4 err_data_crc" : "R10 err_data held", err_data_crc, e_data);
        chk(exp_done ? "R6 err_size" : "R10 err_size held", err_size, e_size);
        chk(exp_done ? "R5 err_short" : "R10 err_short held", err_short, e_short);
        chk(exp_done ? "R7 rev_warn" : "R10 rev_warn held", rev_warn, e_warn);
        chk(exp_done ? "R2 uid" : "R10 uid held", uid, e_uid);
        chk("R3 data_len", data_len, 64'(e_len));
        chk("R3 total_size", total_size, 64'(e_total));
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset done/pass", {done, pass}, 0);
    chk("R11 reset flags", {err_id_crc, err_data_crc, err_size, err_short, rev_warn}, 0);
    chk("R11 reset fields", {uid, data_len, total_size}, 0);
    rst = 1'b0;

    // R10: bytes before any start are ignored (done monitored every cycle)
    build(9, 6'h0, 8'h0, 0, 0, 1);
    send(last_idx, 1'b0, 0, 4);
    chk("R10 idle bytes ignored", {pass, uid}, 0);

    // R1 R2 R3 R4 R8 R9: minimum-size valid ROM with trailing bytes
    do_start(0); build(9, 6'h0, 8'h0, 0, 0, 2); send(last_idx, 1'b1, 0, 3);
    // R6: matching expected size, with gaps between beats
    do_start(0); exp_size_en = 1'b1; exp_size = SIZE_W'(53);
    build(40, 6'h0, 8'h1, 0, 0, 3); send(last_idx, 1'b1, 1, 2);
    // R6: mismatching expected size
    do_start(0); exp_size = SIZE_W'(54);
    build(40, 6'h0, 8'h1, 0, 0, 4); send(last_idx, 1'b1, 0, 0);
    exp_size_en = 1'b0;
    // R1: corrupted identifier checksum
    do_start(0); build(20, 6'h0, 8'h0, 1, 0, 5); send(last_idx, 1'b1, 0, 1);
    // R4: corrupted payload checksum
    do_start(0); build(30, 6'h0, 8'h0, 0, 1, 6); send(last_idx, 1'b1, 2, 1);
    // R5: short ROM, done after byte 15
    do_start(0); build(5, 6'h0, 8'h0, 0, 0, 7); send(last_idx, 1'b1, 0, 3);
    do_start(0); build(0, 6'h0, 8'h0, 0, 0, 8); send(last_idx, 1'b1, 0, 2);
    // R7: revision warning does not fail the check
    do_start(0); build(16, 6'h0, 8'h2, 0, 0, 9); send(last_idx, 1'b1, 0, 0);
    // R3: high bits of byte 15 ignored
    do_start(0); build(12, 6'h2A, 8'h0, 0, 0, 10); send(last_idx, 1'b1, 0, 1);
    // R10: start mid-frame abandons it and clears results
    do_start(0); build(200, 6'h0, 8'h0, 0, 0, 11); send(16, 1'b0, 0, 0);
    do_start(1); build(200, 6'h3F, 8'h0, 0, 0, 12); send(last_idx, 1'b1, 0, 2);
    do_start(1);
    // R3 R4: maximum length
    build(1023, 6'h0, 8'h0, 0, 0, 13); send(last_idx, 1'b1, 0, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule